// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of a byte-wide flash array built from up to four parallel byte lanes that share one address bus. On a start request it issues the unlock write sequence for a byte program, a sector erase or a whole-array erase. While it does so, it drives the flash address bus, the write data and one active-low write strobe per lane, with pulse widths derived from nanosecond timing parameters and the clock period. After the last write it reads a status location until bit 7 of every enabled lane shows that the embedded operation has finished. It then reports completion with a one-cycle done pulse, with a timeout flag set when a programmable cycle budget ran out first.

The sector number of an address is its top three bits (bits 18:16 at the default width), so sector s starts at address s·64K. A sector erase accepts a mask of sectors. The five unlock writes are issued once, and the sector-erase command write then follows once for each selected sector, lowest sector first. The static RAM sharing the data bus is kept deselected for the whole time.

Top module: `flash_cmd_seq`

## Requirements
- R1: With op = 0 (program), the sequencer performs exactly four writes, in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the program data at the target address.
- R2: With op = 1 (sector erase), it writes AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h and 55h at 2AAAh. It then writes 30h at address {s, 16'h0000} once for each set bit s of the sector mask, in ascending order of s.
- R3: With op = 2 (whole-array erase), it performs the same five unlock writes as R2, followed by one write of 10h at 5555h, for six writes in total.
- R4: Bit l of fl_we_n strobes lane l and data byte l sits on bits 8l+7:8l. Only the lanes set in lane_en pulse their strobes. Every unlock and command byte is placed on all lanes at once, and the program data is passed through per lane.
- R5: Each write holds its strobes low for ceil(WP_NS/CLK_NS) cycles. Consecutive writes are separated by exactly ceil(WPH_NS/CLK_NS) cycles with all strobes high. Address and data stay stable while a strobe is low.
- R6: After the last write it performs reads with fl_oe_n low for ceil(OE_NS/CLK_NS) cycles. A program reads the target address, a sector erase reads the base of the lowest selected sector, and a whole-array erase reads address 0. The operation finishes when bit 7 of every enabled lane equals the expected value: the program data's bit 7 for a program, 1 for an erase. A disabled lane is ignored. The finish is a one-cycle done pulse with tmo_err low.
- R7: If polling has not finished, done and tmo_err pulse together exactly tmo_limit cycles after the first cycle with fl_oe_n low.
- R8: sram_cs_n stays high at all times. A write strobe and fl_oe_n are never low together. fl_cs_n is low whenever a strobe or fl_oe_n is low.
- R9: A start asserted while busy is high has no effect on the operation in progress.
- R10: A start with lane_en = 0, with op = 3, or with op = 1 and an empty sector mask produces done one cycle later, with no strobe and no read.
- R11: After reset, all strobes, fl_oe_n, fl_cs_n and sram_cs_n are high, and busy, done and tmo_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 program, 1 sector erase, 2 whole-array erase, 3 none |
| addr | input | ADDR_W | Target address for a program |
| wdata | input | 8·LANES | Program data, one byte per lane |
| lane_en | input | LANES | Lanes taking part in the operation |
| sect_mask | input | SECTORS | Sectors to erase for op 1 |
| tmo_limit | input | TMO_W | Polling budget in clock cycles |
| fl_rdata | input | 8·LANES | Read data from the flash lanes |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | 8·LANES | Flash write data |
| fl_wdrive | output | 1 | High while write data should be driven |
| fl_we_n | output | LANES | Per-lane write strobes, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_cs_n | output | 1 | Flash chip select, active low |
| sram_cs_n | output | 1 | Shared static RAM select, held high |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | Pulses with done when polling timed out |

## Verification
The properties assume that the host raises start only with operation inputs that stay valid on that same edge. They also assume that fl_rdata changes only between status reads, never while a read sample is being taken. The bench drives every input at the falling clock edge and holds it through the next rising edge. Its flash model changes the status bytes only when a new read begins, so each read sees a settled value. Strobe and read windows are counted in whole cycles, which means the minimum-low-time property relies on the default timing, which gives more than one strobe-low cycle.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W  = 19,
  parameter int LANES   = 4,
  parameter int SECTORS = 8,
  parameter int TMO_W   = 32,
  parameter int CLK_NS  = 10,
  parameter int WP_NS   = 45,
  parameter int WPH_NS  = 20,
  parameter int OE_NS   = 35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8*LANES-1:0]   wdata,
  input  logic [LANES-1:0]     lane_en,
  input  logic [SECTORS-1:0]   sect_mask,
  input  logic [TMO_W-1:0]     tmo_limit,
  input  logic [8*LANES-1:0]   fl_rdata,
  output logic [ADDR_W-1:0]    fl_addr,
  output logic [8*LANES-1:0]   fl_wdata,
  output logic                 fl_wdrive,
  output logic [LANES-1:0]     fl_we_n,
  output logic                 fl_oe_n,
  output logic                 fl_cs_n,
  output logic                 sram_cs_n,
  output logic                 busy,
  output logic                 done,
  output logic                 tmo_err
);
  localparam int LOW_R   = (WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int HIGH_R  = (WPH_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_R    = (OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int LOW_CYC  = (LOW_R < 1) ? 1 : LOW_R;
  localparam int HIGH_CYC = (HIGH_R < 1) ? 1 : HIGH_R;
  localparam int RD_CYC   = (RD_R < 1) ? 1 : RD_R;
  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? ((LOW_CYC > RD_CYC) ? LOW_CYC : RD_CYC)
                                             : ((HIGH_CYC > RD_CYC) ? HIGH_CYC : RD_CYC);
  localparam int CW     = $clog2(MAXC + 1);
  localparam int SB     = $clog2(SECTORS);
  localparam int SEC_LSB = ADDR_W - SB;
  localparam logic [ADDR_W-1:0] A_UNL1 = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] A_UNL2 = ADDR_W'(16'h2AAA);
  localparam logic [1:0] OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_WLOW, S_WHIGH, S_RLOW, S_RHIGH} st_t;

  st_t                 state;
  logic [1:0]          op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [8*LANES-1:0]  data_q;
  logic [LANES-1:0]    lane_q;
  logic [SECTORS-1:0]  mask_q, rem_q;
  logic [TMO_W-1:0]    lim_q, tcnt;
  logic [2:0]          idx;
  logic [CW-1:0]       cnt;

  logic [SB-1:0]       cur_sec, first_sec;
  logic [ADDR_W-1:0]   st_addr, poll_addr;
  logic [7:0]          st_byte;
  logic                use_data, last_step, match, tmo_hit, empty_cmd;

  wire is_prog = (op_q == OP_PROG);
  wire is_chip = (op_q == OP_CHIP);

  always_comb begin
    cur_sec = '0;
    first_sec = '0;
    for (int s = SECTORS - 1; s >= 0; s--) begin
      if (rem_q[s])  cur_sec   = SB'(s);
      if (mask_q[s]) first_sec = SB'(s);
    end
  end

  always_comb begin
    st_addr  = A_UNL1;
    st_byte  = 8'hAA;
    use_data = 1'b0;
    case (idx)
      3'd0: begin st_addr = A_UNL1; st_byte = 8'hAA; end
      3'd1: begin st_addr = A_UNL2; st_byte = 8'h55; end
      3'd2: begin st_addr = A_UNL1; st_byte = is_prog ? 8'hA0 : 8'h80; end
      3'd3: begin
        if (is_prog) begin st_addr = addr_q; use_data = 1'b1; end
        else         begin st_addr = A_UNL1; st_byte = 8'hAA; end
      end
      3'd4: begin st_addr = A_UNL2; st_byte = 8'h55; end
      default: begin
        if (is_chip) begin st_addr = A_UNL1; st_byte = 8'h10; end
        else         begin st_addr = {cur_sec, {SEC_LSB{1'b0}}}; st_byte = 8'h30; end
      end
    endcase
  end

  always_comb begin
    match = 1'b1;
    for (int l = 0; l < LANES; l++)
      if (lane_q[l] && (fl_rdata[8*l+7] != (is_prog ? data_q[8*l+7] : 1'b1)))
        match = 1'b0;
  end

  assign poll_addr = is_prog ? addr_q : (is_chip ? '0 : {first_sec, {SEC_LSB{1'b0}}});
  assign last_step = is_prog ? (idx == 3'd3)
                   : is_chip ? (idx == 3'd5)
                   : ((idx == 3'd5) && ((rem_q & (rem_q - 1'b1)) == '0));
  assign tmo_hit   = ({1'b0, tcnt} + {{TMO_W{1'b0}}, 1'b1}) >= {1'b0, lim_q};
  assign empty_cmd = (lane_en == '0) || (op == 2'd3) || ((op == OP_SECT) && (sect_mask == '0));

  assign fl_wdrive = (state == S_WLOW) || (state == S_WHIGH);
  assign fl_addr   = fl_wdrive ? st_addr : poll_addr;
  assign fl_wdata  = use_data ? data_q : {LANES{st_byte}};
  assign fl_we_n   = (state == S_WLOW) ? ~lane_q : '1;
  assign fl_oe_n   = (state != S_RLOW);
  assign fl_cs_n   = (state == S_IDLE);
  assign sram_cs_n = 1'b1;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      lane_q  <= '0;
      mask_q  <= '0;
      rem_q   <= '0;
      lim_q   <= '0;
      tcnt    <= '0;
      idx     <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      tmo_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      tmo_err <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            op_q   <= op;
            addr_q <= addr;
            data_q <= wdata;
            lane_q <= lane_en;
            mask_q <= sect_mask;
            rem_q  <= sect_mask;
            lim_q  <= tmo_limit;
            idx    <= '0;
            cnt    <= '0;
            if (empty_cmd) done <= 1'b1;
            else           state <= S_WLOW;
          end
        end
        S_WLOW: begin
          if (cnt == CW'(LOW_CYC - 1)) begin
            cnt   <= '0;
            state <= S_WHIGH;
          end else cnt <= cnt + 1'b1;
        end
        S_WHIGH: begin
          if (cnt == CW'(HIGH_CYC - 1)) begin
            cnt <= '0;
            if (last_step) begin
              state <= S_RLOW;
              tcnt  <= '0;
            end else begin
              state <= S_WLOW;
              if (idx == 3'd5) rem_q <= rem_q & (rem_q - 1'b1);
              else             idx   <= idx + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_RLOW: begin
          tcnt <= tcnt + 1'b1;
          if ((cnt == CW'(RD_CYC - 1)) && match) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (tmo_hit) begin
            done    <= 1'b1;
            tmo_err <= 1'b1;
            state   <= S_IDLE;
          end else if (cnt == CW'(RD_CYC - 1)) begin
            cnt   <= '0;
            state <= S_RHIGH;
          end else cnt <= cnt + 1'b1;
        end
        S_RHIGH: begin
          tcnt <= tcnt + 1'b1;
          if (tmo_hit) begin
            done    <= 1'b1;
            tmo_err <= 1'b1;
            state   <= S_IDLE;
          end else if (cnt == CW'(HIGH_CYC - 1)) begin
            cnt   <= '0;
            state <= S_RLOW;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W  = 19,
  parameter int LANES   = 4,
  parameter int LOW_CYC = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   fl_addr,
  input logic [8*LANES-1:0]  fl_wdata,
  input logic [LANES-1:0]    fl_we_n,
  input logic                fl_oe_n,
  input logic                fl_cs_n,
  input logic                sram_cs_n,
  input logic                busy,
  input logic                done,
  input logic                tmo_err
);
  wire strobing = (fl_we_n != '1);

  p_sram_high_r8: assert property (@(posedge clk) disable iff (!rst_n) sram_cs_n);
  p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n) !(strobing && !fl_oe_n));
  p_cs_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobing || !fl_oe_n) |-> !fl_cs_n);
  p_stable_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobing && $past(fl_we_n != '1)) |-> ($stable(fl_addr) && $stable(fl_wdata)));
  p_min_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((LOW_CYC > 1) && strobing && ($past(fl_we_n) == '1)) |=> (fl_we_n == $past(fl_we_n)));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_tmo_done_r7: assert property (@(posedge clk) disable iff (!rst_n) tmo_err |-> done);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LOW_CYC(LOW_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_cs_n(fl_cs_n), .sram_cs_n(sram_cs_n),
  .busy(busy), .done(done), .tmo_err(tmo_err)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int CLK_NS   = 10;
  localparam int EXP_LOW  = (45 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_HIGH = (20 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [18:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  lane_en = '0;
  logic [7:0]  sect_mask = '0;
  logic [31:0] tmo_limit = 32'd1000;
  logic [31:0] fl_rdata;
  logic [18:0] fl_addr;
  logic [31:0] fl_wdata;
  logic        fl_wdrive;
  logic [3:0]  fl_we_n;
  logic        fl_oe_n, fl_cs_n, sram_cs_n, busy, done, tmo_err;

  always #(CLK_NS/2) clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .lane_en(lane_en), .sect_mask(sect_mask), .tmo_limit(tmo_limit), .fl_rdata(fl_rdata),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wdrive(fl_wdrive), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .fl_cs_n(fl_cs_n), .sram_cs_n(sram_cs_n), .busy(busy),
    .done(done), .tmo_err(tmo_err)
  );

  int checks = 0;
  int fails  = 0;

  // flash model and bus monitor
  logic [31:0] good_v, bad_v;
  logic [3:0]  stuck = '0;
  int          busy_reads = 0;
  int          polls_seen = 0;
  int          wcount = 0;
  logic [18:0] cap_a [0:15];
  logic [31:0] cap_d [0:15];
  logic [3:0]  cap_l [0:15];
  int          cap_low [0:15];
  int          cap_gap [0:15];
  int          gap_run = 0;
  logic [3:0]  prev_we = 4'hF;
  logic        prev_oe = 1'b1;
  logic [18:0] poll_a;
  logic        poll_on = 1'b0;
  int          pc = 0;
  int          done_pc = -1;
  int          bus_bad = 0;

  always_comb begin
    for (int l = 0; l < 4; l++)
      fl_rdata[8*l +: 8] = (stuck[l] || polls_seen <= busy_reads) ? bad_v[8*l +: 8] : good_v[8*l +: 8];
  end

  always @(negedge clk) begin
    if (sram_cs_n !== 1'b1) bus_bad++;
    if ((fl_we_n != 4'hF) && !fl_oe_n) bus_bad++;
    if (((fl_we_n != 4'hF) || !fl_oe_n) && fl_cs_n) bus_bad++;
    if (fl_we_n != 4'hF) begin
      if (prev_we == 4'hF && wcount < 16) begin
        cap_a[wcount] = fl_addr;
        cap_d[wcount] = fl_wdata;
        cap_l[wcount] = ~fl_we_n;
        cap_low[wcount] = 1;
        cap_gap[wcount] = gap_run;
        wcount++;
      end else if (wcount > 0 && wcount <= 16) cap_low[wcount-1]++;
      gap_run = 0;
    end else gap_run++;
    if (poll_on) pc++;
    if (!fl_oe_n && prev_oe) begin
      polls_seen++;
      if (!poll_on) begin
        poll_on = 1'b1;
        pc = 0;
        poll_a = fl_addr;
      end
    end
    if (done) done_pc = pc;
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input logic [3:0] l);
    for (int i = 0; i < 4; i++) lmask[8*i +: 8] = {8{l[i]}};
  endfunction

  logic [18:0] exp_a [0:15];
  logic [31:0] exp_d [0:15];
  int          exp_n;
  logic        got_done, got_tmo;
  int          op_cycles;

  task automatic run_op(input logic [1:0] o, input logic [18:0] a, input logic [31:0] d,
                        input logic [3:0] l, input logic [7:0] m, input logic [31:0] lim,
                        input int br, input logic [3:0] stk, input bit extra);
    int cyc;
    @(negedge clk);
    wcount = 0; polls_seen = 0; poll_on = 1'b0; pc = 0; done_pc = -1; gap_run = 0;
    busy_reads = br; stuck = stk;
    if (o == 2'd0) begin good_v = d; bad_v = d ^ 32'h8080_8080; end
    else begin good_v = 32'hFFFF_FFFF; bad_v = 32'h0; end
    op = o; addr = a; wdata = d; lane_en = l; sect_mask = m; tmo_limit = lim;
    start = 1'b1;
    @(negedge clk);
    cyc = 1;
    while (!done && cyc < 5000) begin
      start = extra && (cyc == 10);
      if (start) op = 2'd2;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    got_done = done;
    got_tmo = tmo_err;
    op_cycles = cyc;
    @(negedge clk);
  endtask

  task automatic check_writes(input string req, input logic [3:0] l);
    logic [31:0] mk;
    mk = lmask(l);
    chk(wcount == exp_n, req, "write count", 64'(wcount), 64'(exp_n));
    for (int i = 0; i < exp_n && i < wcount; i++) begin
      chk(cap_a[i] == exp_a[i], req, $sformatf("write %0d address", i), 64'(cap_a[i]), 64'(exp_a[i]));
      chk((cap_d[i] & mk) == (exp_d[i] & mk), req, $sformatf("write %0d data", i),
          64'(cap_d[i] & mk), 64'(exp_d[i] & mk));
      chk(cap_l[i] == l, "R4", $sformatf("write %0d lanes", i), 64'(cap_l[i]), 64'(l));
      chk(cap_low[i] == EXP_LOW, "R5", $sformatf("write %0d low width", i), 64'(cap_low[i]), 64'(EXP_LOW));
      if (i > 0)
        chk(cap_gap[i] == EXP_HIGH, "R5", $sformatf("gap before write %0d", i), 64'(cap_gap[i]), 64'(EXP_HIGH));
    end
  endtask

  task automatic set_unlock5();
    exp_a[0] = 19'h5555; exp_d[0] = 32'hAAAA_AAAA;
    exp_a[1] = 19'h2AAA; exp_d[1] = 32'h5555_5555;
    exp_a[2] = 19'h5555; exp_d[2] = 32'h8080_8080;
    exp_a[3] = 19'h5555; exp_d[3] = 32'hAAAA_AAAA;
    exp_a[4] = 19'h2AAA; exp_d[4] = 32'h5555_5555;
  endtask

  task automatic t_reset();
    chk(fl_we_n == 4'hF, "R11", "strobes after reset", 64'(fl_we_n), 64'hF);
    chk(fl_oe_n && fl_cs_n && sram_cs_n, "R11", "oe/cs/sram after reset",
        64'({fl_oe_n, fl_cs_n, sram_cs_n}), 64'h7);
    chk(!busy && !done && !tmo_err, "R11", "busy/done/tmo after reset",
        64'({busy, done, tmo_err}), 64'h0);
  endtask

  task automatic t_program(input logic [3:0] l);
    run_op(2'd0, 19'h3_1234, 32'h80FF_017F, l, 8'h00, 32'd1000, 3, 4'h0, 1'b0);
    exp_n = 4;
    exp_a[0] = 19'h5555; exp_d[0] = 32'hAAAA_AAAA;
    exp_a[1] = 19'h2AAA; exp_d[1] = 32'h5555_5555;
    exp_a[2] = 19'h5555; exp_d[2] = 32'hA0A0_A0A0;
    exp_a[3] = 19'h3_1234; exp_d[3] = 32'h80FF_017F;
    check_writes("R1", l);
    chk(got_done && !got_tmo, "R6", "program done without timeout", 64'({got_done, got_tmo}), 64'h2);
    chk(polls_seen == 4, "R6", "status reads until match", 64'(polls_seen), 64'd4);
    chk(poll_a == 19'h3_1234, "R6", "program poll address", 64'(poll_a), 64'h31234);
  endtask

  task automatic t_sector();
    run_op(2'd1, 19'h5_5555, 32'h0, 4'hF, 8'b1001_0010, 32'd1000, 2, 4'h0, 1'b0);
    set_unlock5();
    exp_n = 8;
    exp_a[5] = 19'h1_0000; exp_d[5] = 32'h3030_3030;
    exp_a[6] = 19'h4_0000; exp_d[6] = 32'h3030_3030;
    exp_a[7] = 19'h7_0000; exp_d[7] = 32'h3030_3030;
    check_writes("R2", 4'hF);
    chk(got_done && !got_tmo, "R6", "sector erase done", 64'({got_done, got_tmo}), 64'h2);
    chk(poll_a == 19'h1_0000, "R6", "sector poll address", 64'(poll_a), 64'h10000);
    chk(polls_seen == 3, "R6", "erase status reads", 64'(polls_seen), 64'd3);
  endtask

  task automatic t_chip();
    run_op(2'd2, 19'h1_2345, 32'h0, 4'b0011, 8'h00, 32'd1000, 2, 4'h0, 1'b0);
    set_unlock5();
    exp_n = 6;
    exp_a[5] = 19'h5555; exp_d[5] = 32'h1010_1010;
    check_writes("R3", 4'b0011);
    chk(got_done && !got_tmo, "R3", "whole erase done", 64'({got_done, got_tmo}), 64'h2);
    chk(poll_a == 19'h0, "R6", "whole erase poll address", 64'(poll_a), 64'h0);
  endtask

  task automatic t_timeout();
    run_op(2'd0, 19'h0_0040, 32'h1122_3344, 4'hF, 8'h00, 32'd40, 100000, 4'h0, 1'b0);
    chk(got_done && got_tmo, "R7", "timeout flagged", 64'({got_done, got_tmo}), 64'h3);
    chk(done_pc == 40, "R7", "cycles from first read to timeout", 64'(done_pc), 64'd40);
  endtask

  task automatic t_lane_and();
    run_op(2'd0, 19'h0_0100, 32'h8000_8000, 4'b0101, 8'h00, 32'd60, 0, 4'b0100, 1'b0);
    chk(got_done && got_tmo, "R6", "one enabled lane still busy blocks completion",
        64'({got_done, got_tmo}), 64'h3);
    run_op(2'd0, 19'h0_0100, 32'h8000_8000, 4'b0101, 8'h00, 32'd60, 0, 4'b0010, 1'b0);
    chk(got_done && !got_tmo, "R6", "disabled lane ignored by poll", 64'({got_done, got_tmo}), 64'h2);
    chk(polls_seen == 1, "R6", "single read when ready", 64'(polls_seen), 64'd1);
  endtask

  task automatic t_empty();
    run_op(2'd0, 19'h0, 32'h0, 4'h0, 8'h00, 32'd1000, 0, 4'h0, 1'b0);
    chk(got_done && op_cycles == 1 && wcount == 0 && polls_seen == 0, "R10", "no lanes",
        64'({got_done, 8'(op_cycles), 8'(wcount), 8'(polls_seen)}), 64'h1_01_00_00);
    run_op(2'd1, 19'h0, 32'h0, 4'hF, 8'h00, 32'd1000, 0, 4'h0, 1'b0);
    chk(got_done && op_cycles == 1 && wcount == 0 && polls_seen == 0, "R10", "empty sector mask",
        64'({got_done, 8'(op_cycles), 8'(wcount), 8'(polls_seen)}), 64'h1_01_00_00);
    run_op(2'd3, 19'h0, 32'h0, 4'hF, 8'hFF, 32'd1000, 0, 4'h0, 1'b0);
    chk(got_done && op_cycles == 1 && wcount == 0 && polls_seen == 0, "R10", "op 3",
        64'({got_done, 8'(op_cycles), 8'(wcount), 8'(polls_seen)}), 64'h1_01_00_00);
  endtask

  task automatic t_restart_ignored();
    run_op(2'd0, 19'h2_0002, 32'h0102_0304, 4'hF, 8'h00, 32'd1000, 0, 4'h0, 1'b1);
    chk(wcount == 4, "R9", "start while busy ignored, write count", 64'(wcount), 64'd4);
    chk(cap_d[3] == 32'h0102_0304, "R9", "program data kept", 64'(cap_d[3]), 64'h01020304);
    repeat (5) @(negedge clk);
    chk(!busy && wcount == 4, "R9", "no second operation", 64'({busy, 8'(wcount)}), 64'h004);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired: actual=hang expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    good_v = '0;
    bad_v = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_program(4'hF);
    t_program(4'b0101);
    t_sector();
    t_chip();
    t_timeout();
    t_lane_and();
    t_empty();
    t_restart_ignored();
    chk(bus_bad == 0, "R8", "sram select, strobe/read clash, chip select", 64'(bus_bad), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule